// File: doc/BRIEF.md
# Hardware Spinlock Bank

This block holds a set of single-bit locks that two requesters (A and B) share to guard common data. Each requester has its own port with a read strobe, a release strobe and a lock index. A read is an atomic test-and-set. If the addressed lock is free, the lock becomes held and the requester receives a nonzero, one-hot grant word. If the lock is already held, the requester receives zero and the lock stays as it was. A release strobe frees the addressed lock no matter which requester claimed it.

Every read and release is judged against the lock state at the start of the cycle. When both requesters read the same free lock in the same cycle, requester A takes it. A status output shows every lock bit at once, and observing it never changes any lock. Responses are registered. Each grant word appears in the cycle after its request and is zero in any cycle that follows a cycle without a read.

Top module: `spinlock_bank`

## Requirements
- R1: While reset is high at a clock edge, every lock is cleared to free. After that edge `lock_state` and both grant words read zero.
- R2: A read of free lock n returns a grant word with only bit n set (value 1 << n) in the next cycle, and from that cycle on `lock_state` bit n is 1.
- R3: A read of a lock that is held returns an all-zero grant word in the next cycle, and the lock stays held.
- R4: A release strobe for lock n frees it in the next cycle whichever requester claimed it, unless a claim of lock n succeeds in the same cycle.
- R5: If both requesters read the same free lock in the same cycle, requester A gets the one-hot grant and requester B gets zero. The two grant words never share a set bit.
- R6: Reads by the two requesters of two different free locks in the same cycle both succeed.
- R7: A read sees the lock state from before the cycle's releases. A read of a held lock that is released in the same cycle returns zero and the lock ends free. A read of a free lock that gets a same-cycle release claims it, and the lock ends held.
- R8: `lock_state` bit n equals the state of lock n after the last clock edge, and observing it has no effect on any lock.
- R9: A grant word is zero in the cycle after any cycle in which its requester did not read.
- R10: A read or release of one lock leaves every other lock's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_rd | input | 1 | Requester A test-and-set read strobe |
| a_wr | input | 1 | Requester A release strobe |
| a_idx | input | 5 | Requester A lock index |
| a_grant | output | 32 | Requester A registered read result, one-hot on success |
| b_rd | input | 1 | Requester B test-and-set read strobe |
| b_wr | input | 1 | Requester B release strobe |
| b_idx | input | 5 | Requester B lock index |
| b_grant | output | 32 | Requester B registered read result, one-hot on success |
| lock_state | output | 32 | Current state of every lock, 1 = held |

## Verification
The hardest cases to reach are same-cycle collisions: both requesters reading one free lock, or one reading a lock while the other releases it. With 32 locks, uniformly random indices would make these collisions rare. The random phase therefore draws most indices from a window of four locks and only occasionally from the full range. Directed steps also force each collision outright, starting from both a held lock and a free lock.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

    // Per-lock action decided each cycle
    typedef enum logic [1:0] {
        LK_KEEP  = 2'd0,
        LK_TAKE  = 2'd1,
        LK_DROP  = 2'd2
    } lock_act_e;

    // Decoded view of one requester port
    typedef struct packed {
        logic rd;
        logic wr;
    } port_op_t;

    // Claim has priority over release when both target a lock in a cycle
    function automatic lock_act_e pick_action(input logic take, input logic drop);
        lock_act_e act;
        if (take)
            act = LK_TAKE;
        else if (drop)
            act = LK_DROP;
        else
            act = LK_KEEP;
        return act;
    endfunction

endpackage

// File: rtl/spl_port_decode.sv
module spl_port_decode
    import spinlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    localparam int IDX_W = $clog2(NUM_LOCKS)
) (
    input  port_op_t             op,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LOCKS-1:0] rd_vec,
    output logic [NUM_LOCKS-1:0] wr_vec
);

    for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_dec
        logic hit;
        assign hit       = (idx == IDX_W'(n));
        assign rd_vec[n] = op.rd & hit;
        assign wr_vec[n] = op.wr & hit;
    end

endmodule

// File: rtl/spl_grant.sv
module spl_grant #(
    parameter int NUM_LOCKS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LOCKS-1:0] held,
    input  logic [NUM_LOCKS-1:0] rd_a,
    input  logic [NUM_LOCKS-1:0] rd_b,
    output logic [NUM_LOCKS-1:0] win_a,
    output logic [NUM_LOCKS-1:0] win_b
);

    // Requester A has fixed priority on a tie for a free lock
    always_comb begin
        win_a = rd_a & ~held;
        win_b = rd_b & ~held & ~rd_a;
    end

    // R5: a lock is never handed to both requesters at once
    p_single_winner_r5: assert property (@(posedge clk) disable iff (rst)
        (win_a & win_b) == '0);

    // R3: a held lock is never granted
    p_no_grant_held_r3: assert property (@(posedge clk) disable iff (rst)
        ((win_a | win_b) & held) == '0);

endmodule

// File: rtl/spl_lock_cell.sv
module spl_lock_cell
    import spinlock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic drop,
    output logic held
);

    lock_act_e act;

    always_comb act = pick_action(take, drop);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
        end else begin
            unique case (act)
                LK_TAKE: held <= 1'b1;
                LK_DROP: held <= 1'b0;
                default: held <= held;
            endcase
        end
    end

    // R2 / R7: a successful claim leaves the lock held
    p_take_holds_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> held);

    // R4: a release without a same-cycle claim frees the lock
    p_drop_frees_r4: assert property (@(posedge clk) disable iff (rst)
        (drop && !take) |=> !held);

    // R10: an untouched lock keeps its state
    p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!take && !drop) |=> $stable(held));

endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank
    import spinlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    localparam int IDX_W = $clog2(NUM_LOCKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 a_rd,
    input  logic                 a_wr,
    input  logic [IDX_W-1:0]     a_idx,
    output logic [NUM_LOCKS-1:0] a_grant,
    input  logic                 b_rd,
    input  logic                 b_wr,
    input  logic [IDX_W-1:0]     b_idx,
    output logic [NUM_LOCKS-1:0] b_grant,
    output logic [NUM_LOCKS-1:0] lock_state
);

    localparam logic [NUM_LOCKS-1:0] ONE = NUM_LOCKS'(1);

    port_op_t               op_a, op_b;
    logic [NUM_LOCKS-1:0]   rd_a_vec, wr_a_vec, rd_b_vec, wr_b_vec;
    logic [NUM_LOCKS-1:0]   win_a, win_b;
    logic [NUM_LOCKS-1:0]   held;

    assign op_a = '{rd: a_rd, wr: a_wr};
    assign op_b = '{rd: b_rd, wr: b_wr};

    spl_port_decode #(.NUM_LOCKS(NUM_LOCKS)) i_dec_a (
        .op(op_a), .idx(a_idx), .rd_vec(rd_a_vec), .wr_vec(wr_a_vec)
    );

    spl_port_decode #(.NUM_LOCKS(NUM_LOCKS)) i_dec_b (
        .op(op_b), .idx(b_idx), .rd_vec(rd_b_vec), .wr_vec(wr_b_vec)
    );

    spl_grant #(.NUM_LOCKS(NUM_LOCKS)) i_grant (
        .clk(clk), .rst(rst), .held(held),
        .rd_a(rd_a_vec), .rd_b(rd_b_vec),
        .win_a(win_a), .win_b(win_b)
    );

    for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_lock
        spl_lock_cell i_cell (
            .clk (clk),
            .rst (rst),
            .take(win_a[n] | win_b[n]),
            .drop(wr_a_vec[n] | wr_b_vec[n]),
            .held(held[n])
        );
    end

    // Registered read results: the one-hot win vector is the grant word
    always_ff @(posedge clk) begin
        if (rst) begin
            a_grant <= '0;
            b_grant <= '0;
        end else begin
            a_grant <= win_a;
            b_grant <= win_b;
        end
    end

    assign lock_state = held;

    // R1: reset leaves every lock free and grants clear
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (lock_state == '0 && a_grant == '0 && b_grant == '0));

    // R2: read of a free lock returns its one-hot word
    p_free_read_a_r2: assert property (@(posedge clk) disable iff (rst)
        (a_rd && !lock_state[a_idx]) |=> (a_grant == (ONE << $past(a_idx))));

    // R3: read of a held lock returns zero
    p_held_read_a_r3: assert property (@(posedge clk) disable iff (rst)
        (a_rd && lock_state[a_idx]) |=> (a_grant == '0));

    p_held_read_b_r3: assert property (@(posedge clk) disable iff (rst)
        (b_rd && lock_state[b_idx]) |=> (b_grant == '0));

    // R5: a tie on one lock leaves B without a grant
    p_tie_b_loses_r5: assert property (@(posedge clk) disable iff (rst)
        (a_rd && b_rd && a_idx == b_idx) |=> (b_grant == '0));

    // R5: grant words never overlap and are one-hot or zero
    p_disjoint_r5: assert property (@(posedge clk) disable iff (rst)
        ((a_grant & b_grant) == '0) && $onehot0(a_grant) && $onehot0(b_grant));

    // R9: no read, no grant
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!a_rd && !b_rd) |=> (a_grant == '0 && b_grant == '0));

    // R8: a granted lock shows as held in the status word
    p_status_held_r8: assert property (@(posedge clk) disable iff (rst)
        ((a_grant | b_grant) & ~lock_state) == '0);

endmodule

// File: tb/test_spinlock_bank.sv
`timescale 1ns/1ps
module test_spinlock_bank;

    localparam int N  = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a_rd = 0, a_wr = 0, b_rd = 0, b_wr = 0;
    logic [IW-1:0] a_idx = '0, b_idx = '0;
    logic [N-1:0]  a_grant, b_grant, lock_state;

    int tests = 0;
    int fails = 0;
    logic [N-1:0] model = '0;
    logic [N-1:0] exp_a, exp_b;

    always #2.5 clk = ~clk;

    spinlock_bank i_spinlock_bank (
        .clk(clk), .rst(rst),
        .a_rd(a_rd), .a_wr(a_wr), .a_idx(a_idx), .a_grant(a_grant),
        .b_rd(b_rd), .b_wr(b_wr), .b_idx(b_idx), .b_grant(b_grant),
        .lock_state(lock_state)
    );

    function automatic logic [N-1:0] bit_of(input logic [IW-1:0] i);
        return N'(1) << i;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one cycle, advance the model from the requirements, check results
    task automatic step(input logic ard, input logic awr, input logic [IW-1:0] ai,
                        input logic brd, input logic bwr, input logic [IW-1:0] bi,
                        input string req);
        logic ga, gb;
        @(negedge clk);
        a_rd = ard; a_wr = awr; a_idx = ai;
        b_rd = brd; b_wr = bwr; b_idx = bi;
        ga = ard && !model[ai];
        gb = brd && !model[bi] && !(ard && ai == bi);
        exp_a = ga ? bit_of(ai) : '0;
        exp_b = gb ? bit_of(bi) : '0;
        model = model & ~((awr ? bit_of(ai) : '0) | (bwr ? bit_of(bi) : '0));
        model = model | exp_a | exp_b;
        @(posedge clk);
        #1;
        check({req, " grant A"}, a_grant, exp_a);
        check({req, " grant B"}, b_grant, exp_b);
        check({req, " state"}, lock_state, model);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 state", lock_state, '0);
        check("R1 grant A", a_grant, '0);
        check("R1 grant B", b_grant, '0);
        @(negedge clk);
        rst = 1'b0;

        step(1, 0, 5'd0,  0, 0, 5'd0,  "R2 claim lowest");
        step(0, 0, 5'd0,  1, 0, 5'd31, "R2 claim highest");
        step(1, 0, 5'd0,  0, 0, 5'd0,  "R3 reread held");
        step(0, 0, 5'd0,  1, 0, 5'd0,  "R3 B reads A-held");
        step(0, 0, 5'd0,  0, 0, 5'd0,  "R9 idle");
        step(0, 0, 5'd0,  0, 1, 5'd0,  "R4 B releases A claim");
        step(1, 0, 5'd7,  1, 0, 5'd7,  "R5 tie");
        step(1, 0, 5'd9,  1, 0, 5'd12, "R6 two locks");
        step(1, 0, 5'd7,  0, 1, 5'd7,  "R7 read held with release");
        step(0, 1, 5'd3,  1, 0, 5'd3,  "R7 read free with release");
        step(0, 1, 5'd9,  0, 0, 5'd0,  "R10 release one");
        step(0, 0, 5'd0,  0, 0, 5'd0,  "R8 status stable");

        for (int k = 0; k < 4000; k++) begin
            logic [IW-1:0] ia, ib;
            logic [3:0] ra, rb;
            ia = ($urandom % 8 == 0) ? IW'($urandom) : IW'($urandom % 4);
            ib = ($urandom % 8 == 0) ? IW'($urandom) : IW'($urandom % 4);
            ra = 4'($urandom);
            rb = 4'($urandom);
            step(ra[0], ra[1] & ra[2], ia, rb[0], rb[1] & rb[2], ib, "R2 R3 R4 R5 R7 R10 random");
        end

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        model = '0;
        check("R1 second reset", lock_state, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule